// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs the external bus cycle of an embedded processor. A request from the core side (address, write data, direction and an upper-byte enable) starts a four-state cycle, T1 to T4. In T1 the low-order shared lines carry the address, and an address strobe pulses so that external logic can latch it. In T2 to T4 the same lines carry data. A full copy of the address appears on dedicated outputs half a clock ahead of the shared lines. These outputs are updated on the falling edge in front of T1.

A ready input stretches the cycle by repeating T3. Read data is captured at the end of the last T3, and a done pulse is given in T4. A hold input floats every address and shared line. Reset floats them too, and while reset is asserted the value on the shared lines is captured into a configuration word. A configuration input can suppress the address phase on the shared lines. A parameter selects the 16-bit variant or the 8-bit variant. In the 8-bit variant, address bits 15..8 go to separate outputs that stay valid for the whole cycle.

Top module: `mux_bus_sequencer`

## Requirements
- R1: With no reset and no hold, the sequencer is idle with `reqReady` high. A request seen on a rising edge starts T1 in the following cycle. `ale` is high in T1 only, for exactly one cycle per bus cycle.
- R2: In T1, when `adrDisable` is low, every shared line is enabled and `adOut` equals `reqAddr[DATA_W-1:0]`.
- R3: In T1, when `adrDisable` is high, no shared line is enabled.
- R4: For a write, `adOut` carries the write data in T2, T3 and T4. Lines 7..0 are enabled. Lines 15..8 (16-bit variant) are enabled only when `reqHiByte` was 1, and otherwise they float. `hiByteEn` equals `reqHiByte` from T1 to T4.
- R5: For a read, all shared lines are released from T2 to T4. `rspData` holds the value on `adIn` at the end of the last T3. `rspDone` is high for the single T4 cycle.
- R6: When `ready` is low at the end of a T3, the cycle repeats T3. With N low samples, `rspDone` comes N cycles later than with none.
- R7: The dedicated address `addrOut` takes the new address on the falling edge before T1, half a clock before the shared lines carry it.
- R8: While `holdReq` or `rst` is high, `addrOe`, `upAddrOe` and every bit of `adOe` are low. While `holdReq` is high, no request is accepted. A cycle already under way keeps its timing.
- R9: While `rst` is high, `cfgWord` takes the value on `adIn` at each rising edge. After reset is released it keeps the last captured value, whatever `adIn` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Power-on reset, active high |
| reqValid | input | 1 | Core request valid |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqAddr | input | ADDR_W | Request address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqData | input | DATA_W | Write data |
| reqHiByte | input | 1 | Upper byte lane enable |
| rspData | output | DATA_W | Captured read data |
| rspDone | output | 1 | Cycle complete (T4) |
| addrOut | output | ADDR_W | Dedicated address, falling-edge timed |
| addrOe | output | 1 | Dedicated address output enable |
| upAddrOut | output | 8 | Address bits 15..8 (8-bit variant) |
| upAddrOe | output | 1 | Enable for upAddrOut |
| adOut | output | DATA_W | Shared address/data value driven out |
| adIn | input | DATA_W | Shared address/data value seen on the pins |
| adOe | output | DATA_W | Per-line enable for the shared lines |
| ale | output | 1 | Address latch strobe, T1 only |
| hiByteEn | output | 1 | High-byte qualifier |
| adrDisable | input | 1 | Suppress address phase on shared lines |
| upAddrEn | input | 1 | Enable upper address outputs (8-bit variant) |
| ready | input | 1 | External ready, sampled at end of T3 |
| holdReq | input | 1 | Bus hold granted; floats outputs |
| cfgWord | output | DATA_W | Configuration captured during reset |

## Verification
Bus hold and the data phase of a write in progress can fall in the same cycle. The bench raises `holdReq` in the first T3 of a write that has wait states. In that cycle every shared and address enable must be low, while the sequencer still counts its wait. One cycle later hold is dropped, and the write data must be driven again with the expected lane enables. The done pulse must land on the cycle predicted from the wait count, and the scoreboard compares the data seen in T4 against the queued write.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_T4
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;     // request taken this cycle (idle)
    logic inCycle;    // T1..T4
    logic isT1;       // address phase
    logic dataPhase;  // T2..T4
    logic capture;    // last T3, ready high
    logic done;       // T4
  } busStrobe_t;

endpackage

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mux_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       ready,
  input  logic       holdReq,
  output logic       reqReady,
  output busStrobe_t strb
);

  busState_e state, stateNext;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid && !holdReq) stateNext = ST_T1;
      ST_T1:   stateNext = ST_T2;
      ST_T2:   stateNext = ST_T3;
      ST_T3:   if (ready) stateNext = ST_T4;
      ST_T4:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady       = (state == ST_IDLE) && !holdReq && !rst;
  assign strb.accept    = reqReady && reqValid;
  assign strb.inCycle   = (state != ST_IDLE);
  assign strb.isT1      = (state == ST_T1);
  assign strb.dataPhase = (state == ST_T2) || (state == ST_T3) || (state == ST_T4);
  assign strb.capture   = (state == ST_T3) && ready;
  assign strb.done      = (state == ST_T4);

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strb.isT1 |=> (!strb.isT1 && state == ST_T2));  // R1
  AST_WAIT_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_T3 && !ready) |=> (state == ST_T3 && !strb.done));  // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strb.done |=> (!strb.done && state == ST_IDLE));  // R5
  AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && holdReq) |=> (state == ST_IDLE));  // R8

endmodule

// File: rtl/mux_bus_dpath.sv
module mux_bus_dpath
  import mux_bus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  busStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqHiByte,
  input  logic [DATA_W-1:0] adIn,
  input  logic              adrDisable,
  input  logic              upAddrEn,
  input  logic              holdReq,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic [7:0]        upAddrOut,
  output logic              upAddrOe,
  output logic [DATA_W-1:0] adOut,
  output logic [DATA_W-1:0] adOe,
  output logic              hiByteEn,
  output logic [DATA_W-1:0] cfgWord
);

  localparam int LO_W = 8;
  localparam int HI_W = DATA_W - LO_W;

  logic [15:0]       addrLowQ;
  logic [DATA_W-1:0] dataQ;
  logic              writeQ;
  logic              hiQ;
  logic [ADDR_W-1:0] addrFallQ;
  logic [DATA_W-1:0] rdQ;
  logic [DATA_W-1:0] cfgQ;
  logic              floatAll;
  logic              drvLo;
  logic              addrPhaseDrv;

  // request registers, loaded when the control accepts
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      addrLowQ <= '0;
      dataQ    <= '0;
      writeQ   <= 1'b0;
      hiQ      <= 1'b0;
    end else if (strb.accept) begin
      addrLowQ <= reqAddr[15:0];
      dataQ    <= reqData;
      writeQ   <= reqWrite;
      hiQ      <= reqHiByte;
    end
  end

  // dedicated address: falling edge gives the half-clock lead
  always_ff @(negedge clk or posedge rst) begin
    if (rst)              addrFallQ <= '0;
    else if (strb.accept) addrFallQ <= reqAddr;
  end

  // read capture at the end of the last T3
  always_ff @(posedge clk or posedge rst) begin
    if (rst)               rdQ <= '0;
    else if (strb.capture) rdQ <= adIn;
  end

  // power-on configuration sampling
  always_ff @(posedge clk) begin
    if (rst) cfgQ <= adIn;
  end

  assign floatAll     = rst || holdReq;
  assign addrPhaseDrv = strb.isT1 && !adrDisable;
  assign drvLo        = !floatAll && (addrPhaseDrv || (strb.dataPhase && writeQ));

  assign rspData = rdQ;
  assign cfgWord = cfgQ;
  assign addrOut = addrFallQ;
  assign addrOe  = !floatAll;
  assign adOut   = strb.isT1 ? addrLowQ[DATA_W-1:0] : dataQ;

  generate
    if (DATA_W == 16) begin : g_wide
      logic drvHi;
      logic unusedUpEn;
      assign unusedUpEn = upAddrEn;
      assign drvHi = !floatAll &&
                     (addrPhaseDrv || (strb.dataPhase && writeQ && hiQ));
      assign adOe      = {{HI_W{drvHi}}, {LO_W{drvLo}}};
      assign hiByteEn  = strb.inCycle && hiQ;
      assign upAddrOut = 8'h00;
      assign upAddrOe  = 1'b0;
    end else begin : g_narrow
      logic unusedHi;
      assign unusedHi  = hiQ;
      assign adOe      = {DATA_W{drvLo}};
      assign hiByteEn  = 1'b0;
      assign upAddrOut = addrLowQ[15:8];
      assign upAddrOe  = upAddrEn && strb.inCycle && !floatAll;
    end
  endgenerate

  AST_ADDR_LEAD: assert property (@(posedge clk) disable iff (rst)
    (strb.isT1 && adOe[0]) |-> (addrOut[DATA_W-1:0] == adOut));  // R7
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (strb.dataPhase && !writeQ) |-> (adOe == '0));  // R5
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(cfgQ));  // R9
  AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (rst)
    holdReq |-> (adOe == '0 && !addrOe && !upAddrOe));  // R8

endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
  import mux_bus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqHiByte,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic [7:0]        upAddrOut,
  output logic              upAddrOe,
  output logic [DATA_W-1:0] adOut,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOe,
  output logic              ale,
  output logic              hiByteEn,
  input  logic              adrDisable,
  input  logic              upAddrEn,
  input  logic              ready,
  input  logic              holdReq,
  output logic [DATA_W-1:0] cfgWord
);

  busStrobe_t strb;

  mux_bus_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .ready    (ready),
    .holdReq  (holdReq),
    .reqReady (reqReady),
    .strb     (strb)
  );

  mux_bus_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .reqData    (reqData),
    .reqHiByte  (reqHiByte),
    .adIn       (adIn),
    .adrDisable (adrDisable),
    .upAddrEn   (upAddrEn),
    .holdReq    (holdReq),
    .rspData    (rspData),
    .addrOut    (addrOut),
    .addrOe     (addrOe),
    .upAddrOut  (upAddrOut),
    .upAddrOe   (upAddrOe),
    .adOut      (adOut),
    .adOe       (adOe),
    .hiByteEn   (hiByteEn),
    .cfgWord    (cfgWord)
  );

  assign ale     = strb.isT1;
  assign rspDone = strb.done;

endmodule

// File: tb/mux_bus_sequencer_test.sv
`timescale 1ns/1ps
module mux_bus_sequencer_test;

  localparam int DW = 16;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst;
  logic          reqValid, reqReady, reqWrite, reqHiByte;
  logic [AW-1:0] reqAddr, addrOut;
  logic [DW-1:0] reqData, rspData, adOut, adIn, adOe, cfgWord;
  logic          rspDone, addrOe, upAddrOe, ale, hiByteEn;
  logic [7:0]    upAddrOut;
  logic          adrDisable, upAddrEn, ready, holdReq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          isRead;
    logic [15:0] data;
  } expItem_t;
  expItem_t sbQ[$];

  always #10 clk = ~clk;  // 50 MHz

  mux_bus_sequencer #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqData(reqData),
    .reqHiByte(reqHiByte), .rspData(rspData), .rspDone(rspDone),
    .addrOut(addrOut), .addrOe(addrOe), .upAddrOut(upAddrOut),
    .upAddrOe(upAddrOe), .adOut(adOut), .adIn(adIn), .adOe(adOe),
    .ale(ale), .hiByteEn(hiByteEn), .adrDisable(adrDisable),
    .upAddrEn(upAddrEn), .ready(ready), .holdReq(holdReq),
    .cfgWord(cfgWord)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every done pulse
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk); #5;
      if (rspDone) begin
        if (sbQ.size() == 0) chk("R5", "done with empty scoreboard", 1, 0);
        else begin
          e = sbQ.pop_front();
          if (e.isRead) chk("R5", "read data", rspData, e.data);
          else          chk("R4", "write data at T4", adOut, e.data);
        end
      end
    end
  end

  // one bus cycle; starts from idle, ends at posedge+5 back in idle
  task automatic runCycle(input logic [19:0] a, input logic w,
                          input logic [15:0] d, input logic hi,
                          input int waits, input bit holdInT3,
                          input bit noAddr);
    logic [15:0] dataOe;
    expItem_t it;
    dataOe = w ? (hi ? 16'hFFFF : 16'h00FF) : 16'h0000;
    @(posedge clk); #1;
    adrDisable = noAddr; reqAddr = a; reqWrite = w; reqData = d;
    reqHiByte = hi; reqValid = 1'b1; ready = (waits == 0);
    if (!w) adIn = d;
    it.isRead = !w; it.data = d;
    sbQ.push_back(it);
    #4;
    chk("R1", "ready in idle", reqReady, 1);
    #10;  // after the falling edge, still ahead of T1
    chk("R7", "dedicated address ahead of T1", addrOut, a);
    chk("R7", "dedicated address enabled", addrOe, 1);
    chk("R7", "shared lines still released", adOe, 0);
    @(posedge clk); #1; reqValid = 1'b0; #4;  // T1
    chk("R1", "ale in T1", ale, 1);
    if (noAddr) chk("R3", "address phase suppressed", adOe, 0);
    else begin
      chk("R2", "address phase enables", adOe, 16'hFFFF);
      chk("R2", "address on shared lines", adOut, a[15:0]);
    end
    chk("R4", "high-byte qualifier T1", hiByteEn, hi);
    @(posedge clk); #5;  // T2
    chk("R1", "ale low in T2", ale, 0);
    chk(w ? "R4" : "R5", "T2 enables", adOe, dataOe);
    if (w) chk("R4", "write data T2", adOut, d);
    for (int k = 0; k <= waits; k++) begin
      @(posedge clk); #1;
      ready = (k == waits);
      if (k == 0) holdReq = holdInT3;
      if (k == 1) holdReq = 1'b0;
      #4;
      chk("R6", "no done during T3", rspDone, 0);
      if (holdInT3 && k == 0) begin
        chk("R8", "hold floats shared lines in T3", adOe, 0);
        chk("R8", "hold floats address", addrOe, 0);
      end else begin
        chk(w ? "R4" : "R5", "T3 enables", adOe, dataOe);
        chk("R4", "high-byte qualifier T3", hiByteEn, hi);
      end
    end
    @(posedge clk); #5;  // T4
    chk("R6", "done after waits", rspDone, 1);
    chk(w ? "R4" : "R5", "T4 enables", adOe, dataOe);
    @(posedge clk); #5;
    chk("R5", "done single cycle", rspDone, 0);
    chk("R1", "back to idle", reqReady, 1);
    adrDisable = 1'b0; ready = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; reqValid = 1'b0; reqAddr = '0; reqWrite = 1'b0;
    reqData = '0; reqHiByte = 1'b0; adIn = 16'hA5C3; adrDisable = 1'b0;
    upAddrEn = 1'b0; ready = 1'b1; holdReq = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    chk("R8", "reset floats shared lines", adOe, 0);
    chk("R8", "reset floats address", addrOe, 0);
    chk("R8", "reset floats upper address", upAddrOe, 0);
    chk("R1", "no ale in reset", ale, 0);
    chk("R9", "config sampled in reset", cfgWord, 16'hA5C3);
    @(posedge clk); #1; rst = 1'b0; adIn = 16'h1234;
    repeat (2) @(posedge clk);
    #5;
    chk("R9", "config held after reset", cfgWord, 16'hA5C3);
    chk("R1", "idle ready after reset", reqReady, 1);
    chk("R1", "no ale when idle", ale, 0);

    // hold blocks acceptance and floats everything
    @(posedge clk); #1; holdReq = 1'b1; reqValid = 1'b1; #4;
    chk("R8", "not ready under hold", reqReady, 0);
    chk("R8", "hold floats shared lines", adOe, 0);
    chk("R8", "hold floats address", addrOe, 0);
    @(posedge clk); #5;
    chk("R8", "no cycle started under hold", ale, 0);
    @(posedge clk); #1; reqValid = 1'b0; holdReq = 1'b0; #4;
    chk("R8", "address enabled after hold", addrOe, 1);
    chk("R8", "still idle after hold", ale, 0);

    runCycle(20'h5A3C1, 1'b1, 16'hBEEF, 1'b1, 0, 1'b0, 1'b0);
    runCycle(20'hF0F0F, 1'b1, 16'h1357, 1'b0, 2, 1'b0, 1'b0);
    runCycle(20'h01234, 1'b0, 16'hC0DE, 1'b1, 0, 1'b0, 1'b0);
    runCycle(20'hABCDE, 1'b0, 16'h7E81, 1'b0, 3, 1'b0, 1'b0);
    runCycle(20'h3FFFF, 1'b1, 16'h55AA, 1'b1, 2, 1'b1, 1'b0);
    runCycle(20'h80001, 1'b1, 16'h0F0F, 1'b1, 1, 1'b1, 1'b1);
    runCycle(20'h4C0DE, 1'b0, 16'h9009, 1'b1, 0, 1'b0, 1'b1);

    @(posedge clk); #5;
    chk("R9", "config unchanged after traffic", cfgWord, 16'hA5C3);
    chk("R5", "scoreboard drained", sbQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule